// File: doc/BRIEF.md
# Destination-Chain Quadword Receive Engine

This block drains an inbound FIFO of 32-bit words and stores the data to memory as 128-bit quadwords. In normal mode software gives it a start address and a quadword count, and the engine streams that many quadwords to consecutive 16-byte slots. In chain mode the count starts at zero. The engine then pulls four-word descriptor tags out of the same FIFO that carries the payload. Each tag names a destination, a payload length and a kind, and the engine keeps following tags until one of them closes the chain.

Data moves in bursts. At the start of each burst the engine sizes the burst from the remaining count and the whole quadwords already waiting in the FIFO. The address and count registers are updated once, when the burst ends. Two tag kinds can also publish a stall address, which is the first byte past their packet, so that a consumer elsewhere knows how far the data has been written. When the work is done the engine raises a one-cycle interrupt and drops its busy (start) bit. A clear pulse abandons the run at any time.

Top module: `dchain_rx`

## Requirements
- R1: In normal mode a start pulse loads `init_addr` and `init_qwc`. The engine then writes exactly `init_qwc` quadwords to `init_addr`, `init_addr+16` and so on. The first word popped for each quadword lands in bits 31:0 and the fourth in bits 127:96.
- R2: In chain mode, whenever the remaining count is zero and the chain is still open, the next four FIFO words form a tag. The destination comes from tag word 1. From tag word 0, bits 15:0 give the count, bits 30:28 give the kind (0 REFE, 1 CNT, 2 NEXT, 3 REF, 4 REFS, 5 CALL, 6 RET, 7 END) and bit 31 is the IRQ flag.
- R3: Neither a burst nor a tag read starts while fewer than four words are in the FIFO. No word is popped in that case.
- R4: A burst moves min(remaining count, FIFO words / 4) quadwords. After it, `cur_addr` has grown by 16 per quadword and `cur_qwc` has shrunk by the number moved.
- R5: A tag of kind END (7) or REFE (0) closes the chain once its own packet has been written. Later FIFO words are left unread.
- R6: A tag whose IRQ flag is set closes the chain after its packet only when tag interrupts were enabled at start. Otherwise the chain continues.
- R7: When the stall select latched at start is nonzero, a REFE or REFS tag sets `stall_addr` to the tag destination plus 16 times its count. With select zero, or with any other kind, `stall_addr` keeps its value.
- R8: When the count is zero and either the mode is normal or the chain is closed, `irq` pulses high for one cycle and `busy` falls in that same cycle.
- R9: A `start_clr` pulse ends the run on the next edge. `busy` falls, no `irq` is raised, and a pending chain close is forgotten, so the next run is not affected.
- R10: After reset, `busy`, `irq`, `fifo_pop`, `mem_we`, `cur_qwc` and `stall_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_set | input | 1 | Start pulse, taken only when idle |
| start_clr | input | 1 | Abort pulse, has priority over start |
| chain_mode | input | 1 | 1 follows tags, 0 uses the normal count; latched at start |
| tie_en | input | 1 | Tag IRQ flag closes the chain; latched at start |
| stall_sel | input | 2 | Nonzero enables stall address updates; latched at start |
| init_addr | input | ADDR_W | Start address for normal mode |
| init_qwc | input | CNT_W | Quadword count for normal mode |
| fifo_level | input | LVL_W | Words currently held by the FIFO |
| fifo_rdata | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Consume the head word this cycle |
| mem_we | output | 1 | Quadword write strobe |
| mem_addr | output | ADDR_W | Byte address of the quadword |
| mem_wdata | output | 128 | Quadword data |
| busy | output | 1 | Start bit; high while a run is active |
| irq | output | 1 | One-cycle completion interrupt |
| cur_addr | output | ADDR_W | Address register |
| cur_qwc | output | CNT_W | Remaining quadword count |
| stall_addr | output | ADDR_W | Stall address register |

## Verification
A bad count or address register shows at the memory port on the very next write, as a quadword at the wrong slot or an extra or missing write. It also shows in the number of FIFO words left over when `irq` fires, because the chain then parses payload as a tag or stops early. A chain-close flag that is wrong in either direction appears within one packet: either `irq` fires while tag words are still queued, or `busy` stays high after the END tag has been drained. The stall register can only change during a tag read, so a bad decode of it is visible once the tag's packet has finished.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

   localparam int QW_WORDS = 4;

   typedef enum logic [2:0] {
      TAG_REFE = 3'd0,
      TAG_CNT  = 3'd1,
      TAG_NEXT = 3'd2,
      TAG_REF  = 3'd3,
      TAG_REFS = 3'd4,
      TAG_CALL = 3'd5,
      TAG_RET  = 3'd6,
      TAG_END  = 3'd7
   } tag_kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_CHECK,
      S_TAG,
      S_DATA
   } rx_state_e;

   typedef struct packed {
      logic [15:0] cnt;
      logic        closes;
      logic        stall_upd;
   } tag_dec_t;

endpackage

// File: rtl/dchain_tag_dec.sv
module dchain_tag_dec
   import dchain_pkg::*;
(
   input  logic [31:0] tag_w0,
   input  logic        tie,
   output tag_dec_t    dec
);

   tag_kind_e kind;
   logic      irq_flag;

   always_comb begin
      kind          = tag_kind_e'(tag_w0[30:28]);
      irq_flag      = tag_w0[31];
      dec.cnt       = tag_w0[15:0];
      dec.closes    = (tie && irq_flag) || (kind == TAG_REFE) || (kind == TAG_END);
      dec.stall_upd = (kind == TAG_REFE) || (kind == TAG_REFS);
   end

endmodule

// File: rtl/dchain_qw_pack.sv
module dchain_qw_pack
   import dchain_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         pop,
   input  logic [31:0]  word,
   output logic         last,
   output logic [31:0]  lane0,
   output logic [31:0]  lane1,
   output logic [127:0] qw
);

   localparam int IDX_W = $clog2(QW_WORDS);

   logic [IDX_W-1:0] widx_q;
   logic [31:0]      lane_q [QW_WORDS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             widx_q <= '0;
      else if (clr)           widx_q <= '0;
      else if (pop)           widx_q <= widx_q + 1'b1;
   end

   generate
      for (genvar g = 0; g < QW_WORDS - 1; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   lane_q[g] <= '0;
            else if (pop && widx_q == IDX_W'(g))          lane_q[g] <= word;
         end
      end
   endgenerate

   assign last  = pop && (widx_q == IDX_W'(QW_WORDS - 1));
   assign lane0 = lane_q[0];
   assign lane1 = lane_q[1];
   assign qw    = {word, lane_q[2], lane_q[1], lane_q[0]};

   p_lane_wraps_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !clr) |=> (widx_q == '0));

endmodule

// File: rtl/dchain_rx.sv
module dchain_rx
   import dchain_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int LVL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_set,
   input  logic              start_clr,
   input  logic              chain_mode,
   input  logic              tie_en,
   input  logic [1:0]        stall_sel,
   input  logic [ADDR_W-1:0] init_addr,
   input  logic [CNT_W-1:0]  init_qwc,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic [31:0]       fifo_rdata,
   output logic              fifo_pop,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [127:0]      mem_wdata,
   output logic              busy,
   output logic              irq,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_qwc,
   output logic [ADDR_W-1:0] stall_addr
);

   localparam int MW = (CNT_W > LVL_W) ? CNT_W : LVL_W;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("dchain_rx: ADDR_W must lie in 8..32");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("dchain_rx: CNT_W must lie in 1..16");
      end
      if (LVL_W < 3) begin : g_bad_lvl
         $error("dchain_rx: LVL_W must be at least 3");
      end
   endgenerate

   rx_state_e         state_q;
   logic [ADDR_W-1:0] addr_q, stall_q;
   logic [CNT_W-1:0]  qwc_q, burst_q, qdone_q, burst_nx;
   logic              busy_q, irq_q, close_q;
   logic              mode_q, tie_q;
   logic [1:0]        ssel_q;

   logic              pk_last, has_qw, burst_end;
   logic [31:0]       lane0, lane1;
   logic [127:0]      qw;
   logic [MW-1:0]     rem_w, avail_w;
   tag_dec_t          dec;

   assign fifo_pop  = (state_q == S_TAG || state_q == S_DATA) && !start_clr;
   assign has_qw    = fifo_level >= LVL_W'(QW_WORDS);
   assign rem_w     = MW'(qwc_q);
   assign avail_w   = MW'(fifo_level >> 2);
   assign burst_nx  = (rem_w < avail_w) ? qwc_q : CNT_W'(avail_w);
   assign burst_end = (qdone_q + 1'b1) == burst_q;

   dchain_qw_pack u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_clr),
      .pop   (fifo_pop),
      .word  (fifo_rdata),
      .last  (pk_last),
      .lane0 (lane0),
      .lane1 (lane1),
      .qw    (qw)
   );

   dchain_tag_dec u_dec (
      .tag_w0 (lane0),
      .tie    (tie_q),
      .dec    (dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         addr_q  <= '0;
         stall_q <= '0;
         qwc_q   <= '0;
         burst_q <= '0;
         qdone_q <= '0;
         busy_q  <= 1'b0;
         irq_q   <= 1'b0;
         close_q <= 1'b0;
         mode_q  <= 1'b0;
         tie_q   <= 1'b0;
         ssel_q  <= '0;
      end else begin
         irq_q <= 1'b0;
         if (start_clr) begin
            busy_q  <= 1'b0;
            close_q <= 1'b0;
            state_q <= S_IDLE;
         end else begin
            unique case (state_q)
               S_IDLE: if (start_set) begin
                  busy_q  <= 1'b1;
                  close_q <= 1'b0;
                  mode_q  <= chain_mode;
                  tie_q   <= tie_en;
                  ssel_q  <= stall_sel;
                  addr_q  <= init_addr;
                  qwc_q   <= chain_mode ? '0 : init_qwc;
                  state_q <= S_CHECK;
               end
               S_CHECK: begin
                  if (qwc_q == '0) begin
                     if (!mode_q || close_q) begin
                        busy_q  <= 1'b0;
                        irq_q   <= 1'b1;
                        close_q <= 1'b0;
                        state_q <= S_IDLE;
                     end else if (has_qw) begin
                        state_q <= S_TAG;
                     end
                  end else if (has_qw) begin
                     burst_q <= burst_nx;
                     qdone_q <= '0;
                     state_q <= S_DATA;
                  end
               end
               S_TAG: if (pk_last) begin
                  addr_q  <= ADDR_W'(lane1);
                  qwc_q   <= CNT_W'(dec.cnt);
                  close_q <= close_q | dec.closes;
                  if (ssel_q != 2'b00 && dec.stall_upd)
                     stall_q <= ADDR_W'(lane1) + (ADDR_W'(dec.cnt) << 4);
                  state_q <= S_CHECK;
               end
               S_DATA: if (pk_last) begin
                  qdone_q <= qdone_q + 1'b1;
                  if (burst_end) begin
                     addr_q  <= addr_q + (ADDR_W'(burst_q) << 4);
                     qwc_q   <= qwc_q - burst_q;
                     state_q <= S_CHECK;
                  end
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end

   assign mem_we     = (state_q == S_DATA) && pk_last;
   assign mem_addr   = addr_q + (ADDR_W'(qdone_q) << 4);
   assign mem_wdata  = qw;
   assign busy       = busy_q;
   assign irq        = irq_q;
   assign cur_addr   = addr_q;
   assign cur_qwc    = qwc_q;
   assign stall_addr = stall_q;

   p_pop_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (fifo_level != '0));

   p_write_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   p_burst_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && burst_end && !start_clr) |=> (cur_qwc < $past(cur_qwc)));

   p_stall_only_on_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_TAG) |=> $stable(stall_addr));

   p_irq_drops_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy);

   p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_clr |=> (!busy && !irq));

endmodule

// File: tb/sim_dchain_rx.sv
`timescale 1ns/1ps
module sim_dchain_rx;

   localparam int ADDR_W = 32;
   localparam int CNT_W  = 16;
   localparam int LVL_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_set = 1'b0, start_clr = 1'b0;
   logic              chain_mode = 1'b0, tie_en = 1'b0;
   logic [1:0]        stall_sel = 2'b00;
   logic [ADDR_W-1:0] init_addr = '0;
   logic [CNT_W-1:0]  init_qwc = '0;
   logic [LVL_W-1:0]  fifo_level = '0;
   logic [31:0]       fifo_rdata = '0;
   logic              fifo_pop, mem_we, busy, irq;
   logic [ADDR_W-1:0] mem_addr, cur_addr, stall_addr;
   logic [127:0]      mem_wdata;
   logic [CNT_W-1:0]  cur_qwc;

   dchain_rx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start_set(start_set), .start_clr(start_clr),
      .chain_mode(chain_mode), .tie_en(tie_en), .stall_sel(stall_sel),
      .init_addr(init_addr), .init_qwc(init_qwc), .fifo_level(fifo_level),
      .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .irq(irq),
      .cur_addr(cur_addr), .cur_qwc(cur_qwc), .stall_addr(stall_addr));

   always #10 clk = ~clk;

   typedef struct { logic [31:0] a; logic [127:0] d; } exp_t;

   logic [31:0] fq[$];
   exp_t        eq[$];
   int          checks = 0, errors = 0, irq_cnt = 0;
   bit          ended = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic refresh();
      fifo_rdata = (fq.size() > 0) ? fq[0] : 32'h0;
      fifo_level = LVL_W'(fq.size());
   endtask

   always @(posedge clk) begin
      if (fifo_pop && fq.size() > 0) begin
         void'(fq.pop_front());
         fifo_rdata <= (fq.size() > 0) ? fq[0] : 32'h0;
         fifo_level <= LVL_W'(fq.size());
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (eq.size() == 0) begin
               chk(1'b0, "R1 unexpected write", 128'(mem_addr), 128'h0);
            end else begin
               exp_t e;
               e = eq.pop_front();
               chk(mem_addr == e.a, "R1 R2 write address", 128'(mem_addr), 128'(e.a));
               chk(mem_wdata == e.d, "R1 write data", mem_wdata, e.d);
            end
         end
         if (irq) irq_cnt++;
      end
   end

   function automatic logic [127:0] mkqw(input int s);
      logic [31:0] b;
      b = 32'hC0DE_0000 + 32'(s) * 32'h11;
      return {b + 32'h3000, b + 32'h2000, b + 32'h1000, b};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_word(input logic [31:0] w);
      fq.push_back(w);
      refresh();
   endtask

   task automatic push_qw(input logic [31:0] a, input logic [127:0] d);
      exp_t e;
      for (int i = 0; i < 4; i++) push_word(d[32*i +: 32]);
      e.a = a; e.d = d;
      eq.push_back(e);
   endtask

   task automatic push_tag(input logic [2:0] kind, input bit irqf, input logic [15:0] cnt, input logic [31:0] a);
      push_word({irqf, kind, 12'h000, cnt});
      push_word(a);
      push_word(32'h0);
      push_word(32'h0);
   endtask

   task automatic flush();
      fq.delete();
      refresh();
   endtask

   task automatic pulse_start();
      start_set = 1'b1;
      tick(1);
      start_set = 1'b0;
   endtask

   task automatic wait_irq(input string req);
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 3000 && !seen; i++) begin
         @(negedge clk);
         if (irq) seen = 1'b1;
      end
      chk(seen, req, 128'(seen), 128'd1);
   endtask

   task automatic finish_sim();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_sim();
   end

   initial begin
      int base;
      logic [127:0] d0, d1;
      refresh();
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R10 reset state
      chk(!busy && !irq, "R10 busy/irq after reset", {busy, irq}, 0);
      chk(!fifo_pop && !mem_we, "R10 pop/we after reset", {fifo_pop, mem_we}, 0);
      chk(cur_qwc == 0 && stall_addr == 0, "R10 count/stall after reset", {cur_qwc, stall_addr}, 0);

      // R1 R8 normal mode, all data present
      chain_mode = 1'b0; init_addr = 32'h100; init_qwc = 16'd3;
      for (int i = 0; i < 3; i++) push_qw(32'h100 + 32'(16 * i), mkqw(i));
      base = irq_cnt;
      pulse_start();
      wait_irq("R8 irq in normal mode");
      tick(3);
      chk(irq_cnt == base + 1, "R8 single irq pulse", irq_cnt, base + 1);
      chk(!busy, "R8 busy cleared", busy, 0);
      chk(eq.size() == 0, "R1 all quadwords written", eq.size(), 0);
      chk(cur_addr == 32'h130 && cur_qwc == 0, "R4 final addr/count normal", {cur_addr, cur_qwc}, {32'h130, 16'h0});

      // R3 R4 partial FIFO contents
      init_addr = 32'h2000; init_qwc = 16'd5;
      pulse_start();
      d0 = mkqw(10); d1 = mkqw(11);
      push_word(d0[31:0]); push_word(d0[63:32]); push_word(d0[95:64]);
      tick(20);
      chk(fq.size() == 3, "R3 no pop below four words", fq.size(), 3);
      chk(busy && cur_qwc == 5, "R3 still waiting", {busy, cur_qwc}, {1'b1, 16'd5});
      begin
         exp_t e;
         e.a = 32'h2000; e.d = d0; eq.push_back(e);
         e.a = 32'h2010; e.d = d1; eq.push_back(e);
      end
      push_word(d0[127:96]);
      for (int i = 0; i < 4; i++) push_word(d1[32*i +: 32]);
      tick(25);
      chk(cur_qwc == 3, "R4 count after burst", cur_qwc, 3);
      chk(cur_addr == 32'h2020, "R4 address after burst", cur_addr, 32'h2020);
      chk(eq.size() == 0, "R4 burst writes done", eq.size(), 0);
      for (int i = 0; i < 3; i++) push_qw(32'h2020 + 32'(16 * i), mkqw(20 + i));
      wait_irq("R8 irq after split bursts");
      tick(2);
      chk(eq.size() == 0 && cur_addr == 32'h2050, "R4 final split addr", cur_addr, 32'h2050);

      // R2 R5 R6 R7 chain with stall select 1, tag interrupts off
      chain_mode = 1'b1; tie_en = 1'b0; stall_sel = 2'd1;
      push_tag(3'd1, 1'b1, 16'd2, 32'h4000);
      push_qw(32'h4000, mkqw(30)); push_qw(32'h4010, mkqw(31));
      push_tag(3'd4, 1'b0, 16'd1, 32'h5000);
      push_qw(32'h5000, mkqw(32));
      push_tag(3'd3, 1'b0, 16'd0, 32'h6000);
      push_tag(3'd7, 1'b0, 16'd1, 32'h7000);
      push_qw(32'h7000, mkqw(33));
      pulse_start();
      wait_irq("R5 chain ends on END");
      tick(2);
      chk(eq.size() == 0, "R6 IRQ flag ignored without enable", eq.size(), 0);
      chk(fq.size() == 0, "R5 END tag consumed fully", fq.size(), 0);
      chk(stall_addr == 32'h5010, "R7 REFS stall address", stall_addr, 32'h5010);
      chk(cur_addr == 32'h7010, "R2 address from tag", cur_addr, 32'h7010);

      // R6 tag interrupt enabled
      tie_en = 1'b1; stall_sel = 2'd0;
      push_tag(3'd1, 1'b1, 16'd1, 32'h8000);
      push_qw(32'h8000, mkqw(40));
      push_tag(3'd7, 1'b0, 16'd0, 32'h0);
      pulse_start();
      wait_irq("R6 irq with tag interrupt");
      tick(2);
      chk(fq.size() == 4, "R6 chain closed before next tag", fq.size(), 4);
      chk(eq.size() == 0, "R6 packet written", eq.size(), 0);
      flush();

      // R5 R7 REFE with stall select zero
      tie_en = 1'b0;
      push_tag(3'd0, 1'b0, 16'd1, 32'h9000);
      push_qw(32'h9000, mkqw(50));
      push_tag(3'd7, 1'b0, 16'd0, 32'h0);
      pulse_start();
      wait_irq("R5 REFE closes chain");
      tick(2);
      chk(fq.size() == 4, "R5 REFE leaves later words", fq.size(), 4);
      chk(stall_addr == 32'h5010, "R7 stall unchanged with select zero", stall_addr, 32'h5010);
      flush();

      // R7 REFE with stall select 2
      stall_sel = 2'd2;
      push_tag(3'd0, 1'b0, 16'd2, 32'hA000);
      push_qw(32'hA000, mkqw(60)); push_qw(32'hA010, mkqw(61));
      pulse_start();
      wait_irq("R5 REFE irq");
      tick(2);
      chk(stall_addr == 32'hA020, "R7 REFE stall address", stall_addr, 32'hA020);

      // R9 abort with a pending close
      tie_en = 1'b1; stall_sel = 2'd0;
      push_tag(3'd1, 1'b1, 16'd3, 32'hB000);
      push_qw(32'hB000, mkqw(70));
      pulse_start();
      tick(30);
      chk(busy && cur_qwc == 2, "R9 run stalled before abort", {busy, cur_qwc}, {1'b1, 16'd2});
      base = irq_cnt;
      start_clr = 1'b1;
      tick(1);
      start_clr = 1'b0;
      chk(!busy, "R9 busy cleared by abort", busy, 0);
      tick(10);
      chk(irq_cnt == base && !busy, "R9 no irq after abort", irq_cnt, base);
      tie_en = 1'b0;
      push_tag(3'd2, 1'b0, 16'd1, 32'hC000);
      push_qw(32'hC000, mkqw(80));
      push_tag(3'd7, 1'b0, 16'd0, 32'h0);
      pulse_start();
      wait_irq("R9 next run completes");
      tick(2);
      chk(fq.size() == 0 && eq.size() == 0, "R9 next run reads all tags", fq.size(), 0);

      finish_sim();
   end

endmodule